// File: doc/BRIEF.md
# Boundary Register with Built-in Signature and Pattern Engine

This block holds the boundary cells of a scan-testable octal buffer. There are 18 cells, and each one pairs a serial shift stage with a shadow stage. Two cells sit on the output-enable pins, eight on the data inputs, and eight on the core-side outputs. Beside the cells sits a 2-bit run-mode register. The TAP controller runs elsewhere and supplies per-state strobes to the block, along with a decoded instruction class. The block supplies the serial outputs of both registers and the shadowed values. Those shadowed values drive the output enables, the buffer outputs and the internal data inputs.

The TAP can load, read, update and self-test the cells. While the run-test instruction is active and the TAP sits in Run-Test/Idle, the cells carry out one of four built-in operations, chosen by the run-mode register:
- output toggling with input sampling;
- a 16-bit pseudo-random pattern generator;
- a 16-bit parallel signature compressor;
- an 8-bit compressor on the inputs paired with an 8-bit generator on the outputs.

One clock edge stands in for both TCK edges. A shadow stage that follows a run-test step takes the new shift value on the same edge.

Top module: `bscan_sig_boundary`

## Requirements
- R1: A capture strobe with the register selected and class SAMPLE (cls_i=1) loads the shift stages. Cell 16+k takes oe_pin_i[k], cell 8+k takes a_pin_i[k], and cell k takes y_core_i[k].
- R2: Each shift strobe with the register selected moves tdi_i into cell 17 and every cell n into cell n-1. bsr_tdo_o always shows cell 0.
- R3: An update strobe with the register selected copies all shift stages into the shadows. oe_o shows shadows 17:16, a_core_o shows shadows 15:8, and y_o shows shadows 7:0.
- R4: On capture, class READ (2) leaves the shift stages unchanged. Class SELFTEST (3) inverts every shift stage.
- R5: The run-mode register has a shift stage and an active stage. Reset and tlr_i both set both stages to 2'b10. Capture leaves it unchanged. A shift moves tdi_i into bit 1 and bcr_tdo_o shows bit 0. An update with sel_bcr_i makes the shifted value active.
- R6: tlr_i alone changes no boundary shift stage and no shadow.
- R7: Mode 00 with class RUNT (4) in Run-Test/Idle does three things on each cycle. Input cells take a_pin_i. Output shift stages invert. Input and output shadows take the new values.
- R8: Mode 01 steps cells 15:0 as an LFSR. Each step shifts toward the higher index, and bit 0 takes bits 15^11^2^0. All input and output shadows follow. An all-zero seed stays zero.
- R9: Mode 10 steps cells 15:0 with the same 16-bit LFSR, then XORs a_pin_i[k] into cell 8+k. Input shadows follow, and output shadows hold.
- R10: Mode 11 treats cells 15:8 and cells 7:0 as two separate 8-bit LFSRs. Each shifts up, and bit 0 takes bits 7^3^2^1. a_pin_i is XORed into the input group. All 16 shadows follow.
- R11: No run-test operation changes cells 17:16 or their shadows.
- R12: Class TOGGLE (5) in Run-Test/Idle inverts only the output shift stages, which their shadows follow. The input cells ignore a_pin_i.
- R13: Outside Run-Test/Idle, and with any class other than RUNT or TOGGLE, no run-test operation is performed and the cells hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset |
| tlr_i | input | 1 | TAP is in Test-Logic-Reset |
| capture_i | input | 1 | TAP is in Capture-DR |
| shift_i | input | 1 | TAP is in Shift-DR |
| update_i | input | 1 | TAP is in Update-DR |
| runidle_i | input | 1 | TAP is in Run-Test/Idle |
| sel_bsr_i | input | 1 | Boundary register is the selected data register |
| sel_bcr_i | input | 1 | Run-mode register is the selected data register |
| cls_i | input | 3 | Instruction class (0 none, 1 sample, 2 read, 3 self test, 4 run test, 5 toggle) |
| tdi_i | input | 1 | Serial data in |
| oe_pin_i | input | 2 | Output-enable pin values |
| a_pin_i | input | 8 | Data input pin values |
| y_core_i | input | 8 | Core-side output values |
| bsr_tdo_o | output | 1 | Boundary register serial out |
| bcr_tdo_o | output | 1 | Run-mode register serial out |
| oe_o | output | 2 | Shadowed output enables |
| a_core_o | output | 8 | Shadowed values for the internal inputs |
| y_o | output | 8 | Shadowed values for the buffer outputs |

## Verification
Some rules are checked by assertions on every cycle:
- the serial shift movement;
- inversion of every cell on a self-test capture;
- the enable cells staying fixed through any run-test step;
- output shadows holding during signature compression;
- an all-zero pattern seed staying zero;
- the run-mode register holding through capture;
- the cells holding when no strobe is active.

Only the directed scenarios can show the correct bit order at capture, the exact LFSR and signature sequences over several steps, and the run-mode register returning to 2'b10 after Test-Logic-Reset. The same applies to pins being ignored in the standalone toggle class. The scenarios read these results both through the shadowed outputs and by scanning the shift stages back out.

// File: rtl/bscan_sig_pkg.sv
package bscan_sig_pkg;

    localparam int OE_W   = 2;
    localparam int DATA_W = 8;
    localparam int SIG_W  = 2 * DATA_W;
    localparam int CELL_W = OE_W + SIG_W;
    localparam int CTL_W  = 2;

    typedef enum logic [2:0] {
        CLS_NONE     = 3'd0,
        CLS_SAMPLE   = 3'd1,
        CLS_READ     = 3'd2,
        CLS_SELFTEST = 3'd3,
        CLS_RUNT     = 3'd4,
        CLS_TOGGLE   = 3'd5
    } cls_e;

    typedef enum logic [CTL_W-1:0] {
        RM_TOGGLE = 2'b00,
        RM_PRPG   = 2'b01,
        RM_PSA    = 2'b10,
        RM_MIX    = 2'b11
    } rmode_e;

    localparam rmode_e RM_RESET = RM_PSA;

    typedef struct packed {
        logic [OE_W-1:0]   en;
        logic [DATA_W-1:0] din;
        logic [DATA_W-1:0] dout;
    } cells_t;

    typedef struct packed {
        logic             active;
        logic             upd_in;
        logic             upd_out;
        logic [SIG_W-1:0] nxt;
    } run_t;

    function automatic logic [SIG_W-1:0] lfsr_wide(input logic [SIG_W-1:0] x);
        return {x[SIG_W-2:0], x[15] ^ x[11] ^ x[2] ^ x[0]};
    endfunction

    function automatic logic [DATA_W-1:0] lfsr_half(input logic [DATA_W-1:0] x);
        return {x[DATA_W-2:0], x[7] ^ x[3] ^ x[2] ^ x[1]};
    endfunction

endpackage

// File: rtl/bscan_mode_reg.sv
module bscan_mode_reg
    import bscan_sig_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   tlr_i,
    input  logic   sel_i,
    input  logic   capture_i,
    input  logic   shift_i,
    input  logic   update_i,
    input  logic   tdi_i,
    output logic   tdo_o,
    output rmode_e mode_o
);
    logic [CTL_W-1:0] stage_q;
    rmode_e           act_q;

    always_ff @(posedge clk) begin
        if (rst || tlr_i) begin
            stage_q <= RM_RESET;
            act_q   <= RM_RESET;
        end else if (sel_i && shift_i) begin
            stage_q <= {tdi_i, stage_q[CTL_W-1:1]};
        end else if (sel_i && update_i) begin
            act_q <= rmode_e'(stage_q);
        end
    end

    assign tdo_o  = stage_q[0];
    assign mode_o = act_q;

    // R5: capture never alters the mode register
    a_r5_capture_holds: assert property (@(posedge clk) disable iff (rst)
        (sel_i && capture_i && !tlr_i) |=> ($stable(stage_q) && $stable(act_q)));

endmodule

// File: rtl/bscan_run_engine.sv
module bscan_run_engine
    import bscan_sig_pkg::*;
(
    input  cls_e              cls_i,
    input  rmode_e            mode_i,
    input  logic              runidle_i,
    input  logic [SIG_W-1:0]  cur_i,
    input  logic [DATA_W-1:0] a_pin_i,
    output run_t              run_o
);
    logic [DATA_W-1:0] cur_in, cur_out;
    assign cur_in  = cur_i[SIG_W-1:DATA_W];
    assign cur_out = cur_i[DATA_W-1:0];

    always_comb begin
        run_o     = '0;
        run_o.nxt = cur_i;
        if (runidle_i) begin
            unique case (cls_i)
                CLS_RUNT: begin
                    run_o.active = 1'b1;
                    unique case (mode_i)
                        RM_TOGGLE: begin
                            run_o.nxt     = {a_pin_i, ~cur_out};
                            run_o.upd_in  = 1'b1;
                            run_o.upd_out = 1'b1;
                        end
                        RM_PRPG: begin
                            run_o.nxt     = lfsr_wide(cur_i);
                            run_o.upd_in  = 1'b1;
                            run_o.upd_out = 1'b1;
                        end
                        RM_PSA: begin
                            run_o.nxt     = lfsr_wide(cur_i) ^ {a_pin_i, {DATA_W{1'b0}}};
                            run_o.upd_in  = 1'b1;
                        end
                        RM_MIX: begin
                            run_o.nxt     = {lfsr_half(cur_in) ^ a_pin_i, lfsr_half(cur_out)};
                            run_o.upd_in  = 1'b1;
                            run_o.upd_out = 1'b1;
                        end
                        default: ;
                    endcase
                end
                CLS_TOGGLE: begin
                    run_o.active  = 1'b1;
                    run_o.nxt     = {cur_in, ~cur_out};
                    run_o.upd_out = 1'b1;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/bscan_cell_store.sv
module bscan_cell_store
    import bscan_sig_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   sel_i,
    input  logic   capture_i,
    input  logic   shift_i,
    input  logic   update_i,
    input  cls_e   cls_i,
    input  logic   tdi_i,
    input  cells_t pins_i,
    input  run_t   run_i,
    output cells_t stage_o,
    output cells_t shadow_o,
    output logic   tdo_o
);
    cells_t stage_q, shadow_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q  <= '0;
            shadow_q <= '0;
        end else if (sel_i && capture_i) begin
            if (cls_i == CLS_SAMPLE)
                stage_q <= pins_i;
            else if (cls_i == CLS_SELFTEST)
                stage_q <= ~stage_q;
        end else if (sel_i && shift_i) begin
            stage_q <= {tdi_i, stage_q[CELL_W-1:1]};
        end else if (sel_i && update_i) begin
            shadow_q <= stage_q;
        end else if (run_i.active) begin
            {stage_q.din, stage_q.dout} <= run_i.nxt;
            if (run_i.upd_in)
                shadow_q.din <= run_i.nxt[SIG_W-1:DATA_W];
            if (run_i.upd_out)
                shadow_q.dout <= run_i.nxt[DATA_W-1:0];
        end
    end

    assign stage_o  = stage_q;
    assign shadow_o = shadow_q;
    assign tdo_o    = stage_q[0];

    // R2: serial movement one cell toward the output per shift
    a_r2_shift_moves: assert property (@(posedge clk) disable iff (rst)
        (sel_i && shift_i && !capture_i) |=>
            (stage_q[CELL_W-2:0] == $past(stage_q[CELL_W-1:1]) && stage_q[CELL_W-1] == $past(tdi_i)));

    // R4: self-test capture inverts every cell
    a_r4_selftest_inverts: assert property (@(posedge clk) disable iff (rst)
        (sel_i && capture_i && cls_i == CLS_SELFTEST) |=> (stage_q == ~$past(stage_q)));

    // R11: enable cells untouched by any run-test step
    a_r11_enables_fixed: assert property (@(posedge clk) disable iff (rst)
        (run_i.active && !sel_i) |=> ($stable(stage_q.en) && $stable(shadow_q.en)));

    // R9: output shadows hold whenever a step leaves them out
    a_r9_out_shadow_holds: assert property (@(posedge clk) disable iff (rst)
        (run_i.active && !run_i.upd_out && !sel_i) |=> $stable(shadow_q.dout));

endmodule

// File: rtl/bscan_sig_boundary.sv
module bscan_sig_boundary
    import bscan_sig_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tlr_i,
    input  logic              capture_i,
    input  logic              shift_i,
    input  logic              update_i,
    input  logic              runidle_i,
    input  logic              sel_bsr_i,
    input  logic              sel_bcr_i,
    input  logic [2:0]        cls_i,
    input  logic              tdi_i,
    input  logic [OE_W-1:0]   oe_pin_i,
    input  logic [DATA_W-1:0] a_pin_i,
    input  logic [DATA_W-1:0] y_core_i,
    output logic              bsr_tdo_o,
    output logic              bcr_tdo_o,
    output logic [OE_W-1:0]   oe_o,
    output logic [DATA_W-1:0] a_core_o,
    output logic [DATA_W-1:0] y_o
);
    cls_e   cls;
    rmode_e mode;
    cells_t pins, stage, shadow;
    run_t   run;

    assign cls  = cls_e'(cls_i);
    assign pins = {oe_pin_i, a_pin_i, y_core_i};

    bscan_mode_reg u_mode (
        .clk(clk), .rst(rst), .tlr_i(tlr_i), .sel_i(sel_bcr_i),
        .capture_i(capture_i), .shift_i(shift_i), .update_i(update_i),
        .tdi_i(tdi_i), .tdo_o(bcr_tdo_o), .mode_o(mode)
    );

    bscan_run_engine u_eng (
        .cls_i(cls), .mode_i(mode), .runidle_i(runidle_i),
        .cur_i({stage.din, stage.dout}), .a_pin_i(a_pin_i), .run_o(run)
    );

    bscan_cell_store u_store (
        .clk(clk), .rst(rst), .sel_i(sel_bsr_i), .capture_i(capture_i),
        .shift_i(shift_i), .update_i(update_i), .cls_i(cls), .tdi_i(tdi_i),
        .pins_i(pins), .run_i(run), .stage_o(stage), .shadow_o(shadow),
        .tdo_o(bsr_tdo_o)
    );

    assign oe_o     = shadow.en;
    assign a_core_o = shadow.din;
    assign y_o      = shadow.dout;

    // R6, R13: with no capture, shift, update or Run-Test/Idle the cells hold
    a_r13_idle_holds: assert property (@(posedge clk) disable iff (rst)
        (!capture_i && !shift_i && !update_i && !runidle_i) |=>
            ($stable(stage) && $stable(shadow)));

    // R8: an all-zero pattern seed stays zero
    a_r8_zero_seed_stays: assert property (@(posedge clk) disable iff (rst)
        (runidle_i && cls == CLS_RUNT && mode == RM_PRPG && !sel_bsr_i &&
         {stage.din, stage.dout} == '0) |=> ({stage.din, stage.dout} == '0));

    // R12: standalone toggle inverts outputs and leaves the input shadows alone
    a_r12_toggle_outputs: assert property (@(posedge clk) disable iff (rst)
        (runidle_i && cls == CLS_TOGGLE && !sel_bsr_i) |=>
            (stage.dout == ~$past(stage.dout) && $stable(a_core_o) && y_o == stage.dout));

endmodule

// File: tb/bscan_sig_boundary_tb.sv
module bscan_sig_boundary_tb_top;
    import bscan_sig_pkg::*;

    logic clk = 1'b0;
    logic rst, tlr, cap, sh, upd, ri, sel_bsr, sel_bcr, tdi;
    logic [2:0] cls;
    logic [1:0] oe_pin;
    logic [7:0] a_pin, y_core;
    logic bsr_tdo, bcr_tdo;
    logic [1:0] oe_o;
    logic [7:0] a_core, y_o;

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    logic [17:0] m_s, m_sh;

    always #4 clk = ~clk;

    bscan_sig_boundary dut_i (
        .clk(clk), .rst(rst), .tlr_i(tlr), .capture_i(cap), .shift_i(sh),
        .update_i(upd), .runidle_i(ri), .sel_bsr_i(sel_bsr), .sel_bcr_i(sel_bcr),
        .cls_i(cls), .tdi_i(tdi), .oe_pin_i(oe_pin), .a_pin_i(a_pin),
        .y_core_i(y_core), .bsr_tdo_o(bsr_tdo), .bcr_tdo_o(bcr_tdo),
        .oe_o(oe_o), .a_core_o(a_core), .y_o(y_o)
    );

    task automatic chk(input string tag, input logic [17:0] act, input logic [17:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] f16(input logic [15:0] x);
        return {x[14:0], x[15] ^ x[11] ^ x[2] ^ x[0]};
    endfunction
    function automatic logic [7:0] f8(input logic [7:0] x);
        return {x[6:0], x[7] ^ x[3] ^ x[2] ^ x[1]};
    endfunction

    function automatic logic [17:0] outs();
        return {oe_o, a_core, y_o};
    endfunction

    task automatic scan_bsr(input logic [17:0] din, output logic [17:0] dout);
        sel_bsr = 1;
        for (int i = 0; i < 18; i++) begin
            tdi = din[i]; dout[i] = bsr_tdo; sh = 1;
            @(negedge clk);
        end
        sh = 0; sel_bsr = 0;
        m_s = din;
    endtask

    task automatic scan_bcr(input logic [1:0] din, output logic [1:0] dout);
        sel_bcr = 1;
        for (int i = 0; i < 2; i++) begin
            tdi = din[i]; dout[i] = bcr_tdo; sh = 1;
            @(negedge clk);
        end
        sh = 0; sel_bcr = 0;
    endtask

    task automatic upd_bsr();
        sel_bsr = 1; upd = 1; @(negedge clk); upd = 0; sel_bsr = 0;
        m_sh = m_s;
    endtask

    task automatic set_mode(input logic [1:0] m);
        logic [1:0] d;
        scan_bcr(m, d);
        sel_bcr = 1; upd = 1; @(negedge clk); upd = 0; sel_bcr = 0;
    endtask

    task automatic cap_bsr(input logic [2:0] c);
        cls = c; sel_bsr = 1; cap = 1; @(negedge clk); cap = 0; sel_bsr = 0;
    endtask

    // one run-test step per cycle, model follows the requirement text
    task automatic run_steps(input string tag, input logic [1:0] m, input logic [2:0] c, input int n);
        logic [15:0] cur, nx;
        for (int i = 0; i < n; i++) begin
            a_pin = 8'h5A ^ 8'(i * 37);
            cls = c; ri = 1;
            cur = m_s[15:0];
            if (c == 3'd5) begin
                nx = {cur[15:8], ~cur[7:0]};
                m_sh[7:0] = nx[7:0];
            end else begin
                case (m)
                    2'b00: nx = {a_pin, ~cur[7:0]};
                    2'b01: nx = f16(cur);
                    2'b10: nx = f16(cur) ^ {a_pin, 8'h00};
                    default: nx = {f8(cur[15:8]) ^ a_pin, f8(cur[7:0])};
                endcase
                m_sh[15:8] = nx[15:8];
                if (m != 2'b10) m_sh[7:0] = nx[7:0];
            end
            m_s[15:0] = nx;
            @(negedge clk);
            chk($sformatf("%s step %0d shadows", tag, i), outs(), m_sh);
        end
        ri = 0; cls = 3'd0;
    endtask

    task automatic read_back(input string tag);
        logic [17:0] exp, got;
        exp = m_s;
        scan_bsr(exp, got);
        chk($sformatf("%s shift stages", tag), got, exp);
    endtask

    task automatic t_reset();
        chk("R3 reset shadows", outs(), 18'h0);
        chk("R5 reset mode bit0 on bcr_tdo", {17'h0, bcr_tdo}, 18'h0);
        chk("R2 reset bsr_tdo", {17'h0, bsr_tdo}, 18'h0);
        m_s = 0; m_sh = 0;
    endtask

    task automatic t_sample();
        logic [17:0] got, v1;
        oe_pin = 2'b01; a_pin = 8'hA5; y_core = 8'h3C;
        cap_bsr(3'd1);
        v1 = 18'h2B4C7;
        scan_bsr(v1, got);
        chk("R1 sample capture bit order", got, {2'b01, 8'hA5, 8'h3C});
        chk("R2 shadows unchanged by shifting", outs(), 18'h0);
        upd_bsr();
        chk("R3 update drives oe/a_core/y", outs(), v1);
    endtask

    task automatic t_read_selftest();
        logic [17:0] got, v2, v3;
        v2 = 18'h1E01F; v3 = 18'h0C3A6;
        oe_pin = 2'b10; a_pin = 8'hFF; y_core = 8'h00;
        cap_bsr(3'd2);
        scan_bsr(v2, got);
        chk("R4 read class holds on capture", got, 18'h2B4C7);
        cap_bsr(3'd3);
        scan_bsr(v3, got);
        chk("R4 self test inverts", got, ~v2);
        upd_bsr();
        chk("R3 second update", outs(), v3);
    endtask

    task automatic t_tlr();
        logic [1:0] b;
        set_mode(2'b01);
        tlr = 1; repeat (3) @(negedge clk); tlr = 0;
        chk("R6 shadows kept across TLR", outs(), m_sh);
        scan_bcr(2'b11, b);
        chk("R5 mode reg back to 10 after TLR", {16'h0, b}, {16'h0, 2'b10});
        sel_bcr = 1; cap = 1; @(negedge clk); cap = 0; sel_bcr = 0;
        scan_bcr(2'b00, b);
        chk("R5 capture keeps mode reg", {16'h0, b}, {16'h0, 2'b11});
        read_back("R6 TLR");
    endtask

    task automatic t_mode(input string tag, input logic [1:0] m, input logic [17:0] seed, input int n);
        logic [17:0] got;
        set_mode(m);
        scan_bsr(seed, got);
        upd_bsr();
        run_steps(tag, m, 3'd4, n);
        chk({tag, " R11 enables"}, {16'h0, oe_o}, {16'h0, seed[17:16]});
        read_back(tag);
    endtask

    task automatic t_toggle_instr();
        logic [17:0] got, seed;
        seed = 18'h2_96E1;
        scan_bsr(seed, got);
        upd_bsr();
        run_steps("R12 toggle class", 2'b10, 3'd5, 3);
        read_back("R12 toggle class");
    endtask

    task automatic t_gating();
        logic [17:0] snap;
        snap = outs();
        cls = 3'd4; ri = 0;
        for (int i = 0; i < 3; i++) begin a_pin = 8'(i * 71); @(negedge clk); end
        chk("R13 RUNT outside Run-Test/Idle holds", outs(), snap);
        cls = 3'd2; ri = 1;
        for (int i = 0; i < 3; i++) begin a_pin = 8'(i * 29 + 5); @(negedge clk); end
        ri = 0; cls = 3'd0;
        chk("R13 other class in Run-Test/Idle holds", outs(), snap);
        read_back("R13 gating");
    endtask

    initial begin
        rst = 1; tlr = 0; cap = 0; sh = 0; upd = 0; ri = 0;
        sel_bsr = 0; sel_bcr = 0; tdi = 0; cls = 3'd0;
        oe_pin = 0; a_pin = 0; y_core = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_sample();
        t_read_selftest();
        t_tlr();
        t_mode("R7 toggle mode", 2'b00, 18'h1_33C5, 4);
        t_mode("R8 PRPG", 2'b01, 18'h3_0001, 6);
        t_mode("R8 PRPG zero seed", 2'b01, 18'h3_0000, 3);
        t_mode("R9 PSA", 2'b10, 18'h2_8F10, 5);
        t_mode("R10 mixed", 2'b11, 18'h1_A55A, 5);
        t_toggle_instr();
        t_gating();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule